// File: doc/BRIEF.md
# Inverting Bidirectional Latched Transceiver

This block links two 8-bit ports, A and B, through two independent storage banks, one per direction of transfer. Each direction has three active-low controls: a path enable, a latch enable and an output enable. With the path and latch enables both low, the bank is transparent. A rising latch enable freezes the bank's contents. The output enable together with the path enable decides whether the far port is driven. The stored or passing data always appears inverted on the far side.

Each port is split into an input bus, an output bus and a single drive-enable flag. The tri-state pad cells therefore sit outside the block. An active-high reset clears both banks and keeps both drive flags off. Nothing arbitrates between the two directions: both may drive at once, and avoiding bus contention is left to the system.

Top module: `inv_latch_xcvr`

## Requirements
- R1: The two banks are independent: controls and data of one direction never change the other direction's output bus.
- R2: While reset is low and both the A-to-B path enable and latch enable are low, `b_o` equals the bitwise inverse of `a_i` and follows every change on `a_i`.
- R3: A low-to-high edge on the A-to-B latch enable keeps the A data present just before the edge; later changes on `a_i` do not reach `b_o`.
- R4: While a direction's path enable is high, its bank holds its contents whatever its latch enable does.
- R5: `b_drv_o` is 1 exactly when reset is low, the A-to-B path enable is low and the A-to-B output enable is low; `a_drv_o` is 1 under the same rule with the B-to-A controls.
- R6: Each output bus always carries the bitwise inverse of its bank's contents, whether or not its drive flag is set, so stored data is visible at the port.
- R7: The B-to-A direction behaves like A-to-B (transparency, capture and hold), taking data from `b_i` to `a_o` under its own three controls.
- R8: While reset is high, both banks are zero, so both output buses read all ones, and both drive flags are 0.
- R9: Both drive flags may be 1 at the same time; neither direction blocks the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_i | input | 1 | Active-high reset: clears both banks and forces both drive flags off |
| a_i | input | 8 | Data received at port A |
| a_o | output | 8 | Inverted contents of the B-to-A bank, presented to port A |
| a_drv_o | output | 1 | Pad enable for port A |
| b_i | input | 8 | Data received at port B |
| b_o | output | 8 | Inverted contents of the A-to-B bank, presented to port B |
| b_drv_o | output | 1 | Pad enable for port B |
| ab_path_n_i | input | 1 | A-to-B path enable, active low |
| ab_le_n_i | input | 1 | A-to-B latch enable, active low; rising edge captures |
| ab_oe_n_i | input | 1 | A-to-B output enable, active low |
| ba_path_n_i | input | 1 | B-to-A path enable, active low |
| ba_le_n_i | input | 1 | B-to-A latch enable, active low; rising edge captures |
| ba_oe_n_i | input | 1 | B-to-A output enable, active low |

## Verification
The block holds no clocked state, so every result is due in the same cycle as the stimulus that causes it. The bench applies each new input set just after a rising clock edge and compares all four outputs at the next falling edge, after the level-sensitive storage has settled. A step changes either data or controls, never both. This keeps a capture edge from coinciding with a data change, so the bench model's view of which data was captured is unambiguous. A bench model of both banks supplies the expected values.

// File: rtl/inv_latch_xcvr.sv
module inv_latch_xcvr #(
  parameter int W = 8
) (
  input  logic         rst_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic         a_drv_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic         b_drv_o,
  input  logic         ab_path_n_i,
  input  logic         ab_le_n_i,
  input  logic         ab_oe_n_i,
  input  logic         ba_path_n_i,
  input  logic         ba_le_n_i,
  input  logic         ba_oe_n_i
);
  logic [W-1:0] ab_q, ba_q;
  logic         ab_open, ba_open;

  assign ab_open = ~ab_path_n_i & ~ab_le_n_i;
  assign ba_open = ~ba_path_n_i & ~ba_le_n_i;

  always_latch begin
    if (rst_i)        ab_q <= '0;
    else if (ab_open) ab_q <= a_i;
  end

  always_latch begin
    if (rst_i)        ba_q <= '0;
    else if (ba_open) ba_q <= b_i;
  end

  assign b_o     = ~ab_q;
  assign a_o     = ~ba_q;
  assign b_drv_o = ~rst_i & ~ab_path_n_i & ~ab_oe_n_i;
  assign a_drv_o = ~rst_i & ~ba_path_n_i & ~ba_oe_n_i;
endmodule

// File: rtl/inv_latch_xcvr_chk.sv
module inv_latch_xcvr_chk #(
  parameter int W = 8
) (
  input logic         rst_i,
  input logic [W-1:0] a_i,
  input logic [W-1:0] a_o,
  input logic         a_drv_o,
  input logic [W-1:0] b_i,
  input logic [W-1:0] b_o,
  input logic         b_drv_o,
  input logic         ab_path_n_i,
  input logic         ab_le_n_i,
  input logic         ab_oe_n_i,
  input logic         ba_path_n_i,
  input logic         ba_le_n_i,
  input logic         ba_oe_n_i
);
  always_comb begin
    AST_RESET_QUIET: assert (!rst_i || (!a_drv_o && !b_drv_o)) else $error("reset drive"); // R8
    AST_RESET_CLEAR: assert (!rst_i || (&a_o && &b_o)) else $error("reset clear"); // R8
    AST_AB_TRANSPARENT: assert (rst_i || ab_path_n_i || ab_le_n_i || (b_o == ~a_i)) else $error("ab transparent"); // R2
    AST_BA_TRANSPARENT: assert (rst_i || ba_path_n_i || ba_le_n_i || (a_o == ~b_i)) else $error("ba transparent"); // R7
    AST_B_DRIVE_GATED: assert (!b_drv_o || (!ab_path_n_i && !ab_oe_n_i)) else $error("b drive"); // R5
    AST_A_DRIVE_GATED: assert (!a_drv_o || (!ba_path_n_i && !ba_oe_n_i)) else $error("a drive"); // R5
  end
endmodule

bind inv_latch_xcvr inv_latch_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/tb_inv_latch_xcvr.sv
module tb_inv_latch_xcvr;
  localparam int W = 8;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_i = 1'b1;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] a_o, b_o;
  logic         a_drv_o, b_drv_o;
  logic ab_path_n_i = 1'b1, ab_le_n_i = 1'b1, ab_oe_n_i = 1'b1;
  logic ba_path_n_i = 1'b1, ba_le_n_i = 1'b1, ba_oe_n_i = 1'b1;

  inv_latch_xcvr #(.W(W)) dut (.*);

  int checks = 0, failures = 0, cycles = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;
  logic [W-1:0] cur_a = '0, cur_b = '0;
  logic [2:0]   cur_abc = 3'b111, cur_bac = 3'b111;
  logic         cur_rst = 1'b1;

  function automatic logic exp_drv(input logic r, input logic [2:0] c);
    return !r && !c[2] && !c[0];
  endfunction

  function automatic logic [W-1:0] next_bank(input logic r, input logic [2:0] c,
                                             input logic [W-1:0] d, input logic [W-1:0] q);
    if (r) return '0;
    if (!c[2] && !c[1]) return d;
    return q;
  endfunction

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // abc/bac = {path_n, le_n, oe_n}
  task automatic step(input logic r, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [2:0] abc, input logic [2:0] bac, input string tag);
    @(posedge clk);
    rst_i = r; a_i = a; b_i = b;
    {ab_path_n_i, ab_le_n_i, ab_oe_n_i} = abc;
    {ba_path_n_i, ba_le_n_i, ba_oe_n_i} = bac;
    cur_rst = r; cur_a = a; cur_b = b; cur_abc = abc; cur_bac = bac;
    m_ab = next_bank(r, abc, a, m_ab);
    m_ba = next_bank(r, bac, b, m_ba);
    @(negedge clk);
    cmp({tag, " b_o R6"}, b_o, ~m_ab);
    cmp({tag, " a_o R6"}, a_o, ~m_ba);
    cmp({tag, " b_drv R5"}, W'(b_drv_o), W'(exp_drv(r, abc)));
    cmp({tag, " a_drv R5"}, W'(a_drv_o), W'(exp_drv(r, bac)));
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h1234);
    step(1, 8'h5A, 8'hC3, 3'b000, 3'b000, "R8 reset");
    cmp("R8 reset b_o ones", b_o, '1);
    cmp("R8 reset a_o ones", a_o, '1);
    step(0, 8'h5A, 8'hC3, 3'b001, 3'b111, "R2 open");
    cmp("R2 b_o inverse of a", b_o, 8'hA5);
    step(0, 8'h3C, 8'hC3, 3'b001, 3'b111, "R2 follow");
    cmp("R2 b_o follows", b_o, 8'hC3);
    step(0, 8'h3C, 8'hC3, 3'b011, 3'b111, "R3 capture");
    step(0, 8'hFF, 8'hC3, 3'b011, 3'b111, "R3 hold");
    cmp("R3 b_o held", b_o, 8'hC3);
    step(0, 8'hFF, 8'h00, 3'b010, 3'b111, "R5 drive");
    cmp("R5 b_drv on", W'(b_drv_o), W'(1));
    step(0, 8'h11, 8'h00, 3'b100, 3'b111, "R4 path high");
    cmp("R4 bank held", b_o, 8'hC3);
    step(0, 8'h11, 8'h81, 3'b100, 3'b000, "R7 open");
    cmp("R7 a_o inverse of b", a_o, 8'h7E);
    cmp("R1 b_o untouched", b_o, 8'hC3);
    step(0, 8'h11, 8'h81, 3'b100, 3'b010, "R7 capture");
    step(0, 8'h11, 8'h42, 3'b100, 3'b010, "R7 hold");
    cmp("R7 a_o held", a_o, 8'h7E);
    step(0, 8'h11, 8'h42, 3'b010, 3'b010, "R9 both");
    cmp("R9 both drive", W'({a_drv_o, b_drv_o}), W'(2'b11));
    step(1, 8'h11, 8'h42, 3'b010, 3'b010, "R8 reset again");
    cmp("R8 drives off", W'({a_drv_o, b_drv_o}), W'(0));
    for (int i = 0; i < 3000; i++) begin
      logic r;
      logic [W-1:0] a, b;
      logic [2:0] abc, bac;
      r = ($urandom % 60) == 0;
      a = cur_a; b = cur_b; abc = cur_abc; bac = cur_bac;
      if ($urandom % 2) begin
        a = W'($urandom); b = W'($urandom);
      end else begin
        abc = 3'($urandom); bac = 3'($urandom);
      end
      step(r, a, b, abc, bac, "R1 R6 random");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule